// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block gives outside logic a bit-serial way to overwrite the path overhead bytes of an outgoing STS-1 payload envelope. It serves several channels, and the channels are fully independent. For each channel it makes a port clock as a one-cycle enable pulse in the system clock domain. It also drives a byte strobe that warns the outside logic one port period ahead of each overhead byte, and a frame marker that does the same for the first byte of the frame. The outside logic requests insertion by holding an insert line high. While that line is high, it shifts the byte in most significant bit first, one bit per port period.

When each byte slot closes, the block hands the downstream transmit overhead processor three things: the assembled byte, its position in the overhead column, and a substitute flag. The processor replaces its own byte only when the flag is set. A byte is flagged only when the insert line stayed high for all eight bits. For the parity byte there is one more condition: its per-channel override bit must also be set. A start-of-frame pulse from the mapper realigns the strobes and the byte position of a channel.

Top module: `ohp_insert_port`

## Requirements
- R1: While reset is active and before the first start-of-frame, every strobe, valid and substitute output of every channel is low, and the parity override bits are all clear.
- R2: Each channel's port clock enable is a single system-clock pulse, repeating every DIV system clocks.
- R3: A start-of-frame pulse on a channel raises its byte strobe and frame marker at the next system clock edge, at byte position 0. It also restarts the divider, so the first port clock enable follows DIV-1 clocks after that edge.
- R4: The byte strobe stays high for exactly eight port periods. The first bit is taken at the end of the first of those periods. After a byte ends, the strobe rises again after GAP port periods.
- R5: The frame marker is high only during the strobe of byte position 0, for exactly eight port periods.
- R6: A bit is sampled only on a port clock enable inside the strobe while the insert line is high, and bits fill the byte most significant bit first. A byte whose insert line stayed low in every period returns zero data and no substitute flag, whatever the data pin did.
- R7: One system clock after the eighth sampling edge of a slot, the byte valid output pulses for one clock. At the same time it presents the slot's 4-bit position. Positions run 0 to 8 in the order J1, B3, C2, G1, F2, H4, Z3, Z4, Z5, then wrap to 0.
- R8: The substitute flag is set only if the insert line was high in all eight bit periods. The byte output then carries the assembled byte; otherwise it is zero and the partial bits are dropped.
- R9: Position 1 (B3) is flagged for substitution only when the channel's override bit is set. A write strobe loads every channel's override bit from the configuration input.
- R10: The channels share nothing except the clock, reset and configuration write. Activity on one channel does not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | NCH | Per-channel start-of-frame pulse from the mapper |
| ins_i | input | NCH | Per-channel insert request |
| data_i | input | NCH | Per-channel serial overhead data |
| cfg_wr_i | input | 1 | Load strobe for the parity override bits |
| cfg_b3_ovr_i | input | NCH | Per-channel parity override enable value |
| oh_clk_en_o | output | NCH | Per-channel port clock enable |
| frame_o | output | NCH | Per-channel frame marker |
| byte_en_o | output | NCH | Per-channel byte strobe |
| byte_vld_o | output | NCH | Per-channel assembled-byte valid |
| byte_idx_o | output | 4*NCH | Per-channel byte position (channel c at bits 4c+3:4c) |
| byte_o | output | 8*NCH | Per-channel assembled byte (channel c at bits 8c+7:8c) |
| subst_o | output | NCH | Per-channel substitute flag |

## Verification
The hardest cases to reach from the ports are insert requests that drop partway through a byte. Examples are a request that falls just before the last bit, and one that rises one bit late. A slip of a single sampling edge in either direction would still give a plausible byte. The bench drives every bit in step with the observed port clock enable. Its vector table mixes full, empty, late-start and early-drop insert masks over one whole frame and its wrap. It then repeats the parity position with the override on, and checks that a following full byte has no leftover bits.

// File: rtl/ohp_pkg.sv
package ohp_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 4;
  localparam int NUM_OH  = 9;

  typedef enum logic [IDX_W-1:0] {
    OH_J1 = 4'd0,
    OH_B3 = 4'd1,
    OH_C2 = 4'd2,
    OH_G1 = 4'd3,
    OH_F2 = 4'd4,
    OH_H4 = 4'd5,
    OH_Z3 = 4'd6,
    OH_Z4 = 4'd7,
    OH_Z5 = 4'd8
  } oh_idx_e;
endpackage

// File: rtl/ohp_tick_gen.sv
module ohp_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  output logic tick_o
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (sof_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // sof wins over a coincident tick so realignment is clean
  assign tick_o = (cnt_q == LAST) && !sof_i;
endmodule

// File: rtl/ohp_sched.sv
module ohp_sched
  import ohp_pkg::*;
#(
  parameter int GAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             tick_i,
  output logic             byte_en_o,
  output logic             frame_o,
  output logic             sample_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SLOT  = BYTE_W + GAP;
  localparam int POS_W = $clog2(SLOT);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(SLOT - 1);
  localparam logic [POS_W-1:0] POS_BITS = POS_W'(BYTE_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NUM_OH - 1);

  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      idx_q <= '0;
    end else if (sof_i) begin
      run_q <= 1'b1;
      pos_q <= '0;
      idx_q <= IDX_W'(OH_J1);
    end else if (tick_i && run_q) begin
      if (pos_q == POS_END) begin
        pos_q <= '0;
        idx_q <= (idx_q == IDX_END) ? '0 : idx_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign byte_en_o = run_q && (pos_q < POS_BITS);
  assign frame_o   = byte_en_o && (idx_q == IDX_W'(OH_J1));
  assign sample_o  = tick_i && byte_en_o;
  assign first_o   = (pos_q == '0);
  assign last_o    = (pos_q == POS_LAST);
  assign idx_o     = idx_q;
endmodule

// File: rtl/ohp_assembler.sv
module ohp_assembler
  import ohp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ins_i,
  input  logic              data_i,
  input  logic              b3_ovr_i,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              subst_o
);
  logic [BYTE_W-2:0] shift_q;
  logic              all_q;
  logic              full;
  logic              take;

  // all eight periods must carry the request
  assign full = (first_i ? 1'b1 : all_q) && ins_i;
  assign take = full && ((idx_i != IDX_W'(OH_B3)) || b3_ovr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      all_q   <= 1'b0;
    end else if (sample_i) begin
      all_q <= full;
      if (ins_i) shift_q <= {shift_q[BYTE_W-3:0], data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      idx_o   <= '0;
      byte_o  <= '0;
      subst_o <= 1'b0;
    end else if (sample_i && last_i) begin
      vld_o   <= 1'b1;
      idx_o   <= idx_i;
      byte_o  <= take ? {shift_q, data_i} : '0;
      subst_o <= take;
    end else begin
      vld_o   <= 1'b0;
      byte_o  <= '0;
      subst_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ohp_chan.sv
module ohp_chan
  import ohp_pkg::*;
#(
  parameter int DIV = 4,
  parameter int GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              ins_i,
  input  logic              data_i,
  input  logic              b3_ovr_i,
  output logic              tick_o,
  output logic              frame_o,
  output logic              byte_en_o,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              subst_o
);
  logic             sample;
  logic             first;
  logic             last;
  logic [IDX_W-1:0] idx;

  ohp_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .tick_o (tick_o)
  );

  ohp_sched #(.GAP(GAP)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .tick_i    (tick_o),
    .byte_en_o (byte_en_o),
    .frame_o   (frame_o),
    .sample_o  (sample),
    .first_o   (first),
    .last_o    (last),
    .idx_o     (idx)
  );

  ohp_assembler u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .first_i  (first),
    .last_i   (last),
    .idx_i    (idx),
    .ins_i    (ins_i),
    .data_i   (data_i),
    .b3_ovr_i (b3_ovr_i),
    .vld_o    (vld_o),
    .idx_o    (idx_o),
    .byte_o   (byte_o),
    .subst_o  (subst_o)
  );
endmodule

// File: rtl/ohp_insert_port.sv
module ohp_insert_port
  import ohp_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DIV = 4,
  parameter int GAP = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        sof_i,
  input  logic [NCH-1:0]        ins_i,
  input  logic [NCH-1:0]        data_i,
  input  logic                  cfg_wr_i,
  input  logic [NCH-1:0]        cfg_b3_ovr_i,
  output logic [NCH-1:0]        oh_clk_en_o,
  output logic [NCH-1:0]        frame_o,
  output logic [NCH-1:0]        byte_en_o,
  output logic [NCH-1:0]        byte_vld_o,
  output logic [IDX_W*NCH-1:0]  byte_idx_o,
  output logic [BYTE_W*NCH-1:0] byte_o,
  output logic [NCH-1:0]        subst_o
);
  logic [NCH-1:0] b3_ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       b3_ovr_q <= '0;
    else if (cfg_wr_i) b3_ovr_q <= cfg_b3_ovr_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ohp_chan #(.DIV(DIV), .GAP(GAP)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sof_i     (sof_i[c]),
      .ins_i     (ins_i[c]),
      .data_i    (data_i[c]),
      .b3_ovr_i  (b3_ovr_q[c]),
      .tick_o    (oh_clk_en_o[c]),
      .frame_o   (frame_o[c]),
      .byte_en_o (byte_en_o[c]),
      .vld_o     (byte_vld_o[c]),
      .idx_o     (byte_idx_o[c*IDX_W +: IDX_W]),
      .byte_o    (byte_o[c*BYTE_W +: BYTE_W]),
      .subst_o   (subst_o[c])
    );
  end
endmodule

// File: rtl/ohp_insert_port_chk.sv
module ohp_insert_port_chk #(
  parameter int NCH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCH-1:0]   sof_i,
  input logic [NCH-1:0]   oh_clk_en_o,
  input logic [NCH-1:0]   frame_o,
  input logic [NCH-1:0]   byte_en_o,
  input logic [NCH-1:0]   byte_vld_o,
  input logic [4*NCH-1:0] byte_idx_o,
  input logic [NCH-1:0]   subst_o,
  input logic [NCH-1:0]   b3_ovr_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [3:0] fcnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      fcnt_q <= '0;
      else if (sof_i[c] || !frame_o[c]) fcnt_q <= '0;
      else if (oh_clk_en_o[c])          fcnt_q <= fcnt_q + 1'b1;
    end

    assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oh_clk_en_o[c] |=> !oh_clk_en_o[c]);

    assert_en_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(byte_en_o[c]) |-> $past(oh_clk_en_o[c] || sof_i[c]));

    assert_frame_in_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_o[c] |-> byte_en_o[c]);

    assert_frame_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_o[c] |-> (fcnt_q < 4'd8));

    assert_vld_after_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_vld_o[c] |-> $past(oh_clk_en_o[c]));

    assert_subst_has_vld_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      subst_o[c] |-> byte_vld_o[c]);

    assert_b3_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (subst_o[c] && byte_idx_o[c*4 +: 4] == 4'd1) |-> b3_ovr_q[c]);
  end
endmodule

bind ohp_insert_port ohp_insert_port_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .oh_clk_en_o (oh_clk_en_o),
  .frame_o     (frame_o),
  .byte_en_o   (byte_en_o),
  .byte_vld_o  (byte_vld_o),
  .byte_idx_o  (byte_idx_o),
  .subst_o     (subst_o),
  .b3_ovr_q    (b3_ovr_q)
);

// File: tb/ohp_insert_port_bench.sv
module ohp_insert_port_bench;
  localparam int NCH = 3;
  localparam int DIV = 4;
  localparam int GAP = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   sof = '0, ins = '0, din = '0, cfg_ovr = '0;
  logic             cfg_wr = 1'b0;
  logic [NCH-1:0]   tick, frame, ben, vld, subst;
  logic [4*NCH-1:0] idx;
  logic [8*NCH-1:0] bytes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  ohp_insert_port #(.NCH(NCH), .DIV(DIV), .GAP(GAP)) u_ohp_insert_port (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .ins_i(ins), .data_i(din),
    .cfg_wr_i(cfg_wr), .cfg_b3_ovr_i(cfg_ovr), .oh_clk_en_o(tick),
    .frame_o(frame), .byte_en_o(ben), .byte_vld_o(vld), .byte_idx_o(idx),
    .byte_o(bytes), .subst_o(subst)
  );

  // mask (insert request per bit, MSB first) and data per slot, one frame
  localparam logic [15:0] VEC [10] = '{
    {8'hFF, 8'hA5},  // J1 full
    {8'hFF, 8'h3C},  // B3 full, override off
    {8'h00, 8'h69},  // C2 request never raised
    {8'hFE, 8'hC3},  // G1 drops before last bit
    {8'hFF, 8'h81},  // F2 full after a partial
    {8'h7F, 8'h5E},  // H4 starts one bit late
    {8'hFF, 8'h00},  // Z3 full zero
    {8'hFF, 8'hFF},  // Z4 full ones
    {8'hF0, 8'hF7},  // Z5 half
    {8'hFF, 8'h4B}   // wrap back to J1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_sub(input logic [7:0] m, input int i, input bit ovr);
    return (m == 8'hFF) && (i != 1 || ovr);
  endfunction

  task automatic do_sof(input int ch);
    @(negedge clk); sof[ch] = 1'b1;
    @(negedge clk); sof[ch] = 1'b0;
  endtask

  // feed one slot and check its result
  task automatic feed(input int ch, input logic [7:0] m, input logic [7:0] d,
                      input int ei, input bit ovr);
    bit en_ok = 1'b1;
    bit es;
    while (!ben[ch]) @(negedge clk);
    check(frame[ch] == (ei == 0), "R5", frame[ch], ei == 0);
    for (int b = 7; b >= 0; b--) begin
      ins[ch] = m[b];
      din[ch] = d[b];
      while (!tick[ch]) @(negedge clk);
      if (!ben[ch]) en_ok = 1'b0;
      @(negedge clk);
    end
    ins[ch] = 1'b0;
    din[ch] = ~din[ch];
    es = exp_sub(m, ei, ovr);
    check(en_ok, "R4", en_ok, 1);
    check(vld[ch] == 1'b1, "R7", vld[ch], 1);
    check(idx[ch*4 +: 4] == 4'(ei), "R7", idx[ch*4 +: 4], ei);
    check(subst[ch] == es, "R8", subst[ch], es);
    check(bytes[ch*8 +: 8] == (es ? d : 8'h00), "R6", bytes[ch*8 +: 8], es ? d : 8'h00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check({frame, ben, vld, subst} == '0, "R1", {frame, ben, vld, subst}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check({frame, ben, vld, subst} == '0, "R1", {frame, ben, vld, subst}, 0);

    // R3 realignment and lead period
    do_sof(0);
    check(ben[0] && frame[0], "R3", {ben[0], frame[0]}, 3);
    n = 0;
    while (!tick[0]) begin n++; @(negedge clk); end
    check(n == DIV - 1, "R3", n, DIV - 1);
    // R2 tick period
    @(negedge clk);
    n = 1;
    while (!tick[0]) begin n++; @(negedge clk); end
    check(n == DIV, "R2", n, DIV);

    // vector table: one frame plus wrap on channel 0
    do_sof(0);
    for (int v = 0; v < 10; v++) begin
      feed(0, VEC[v][15:8], VEC[v][7:0], v % 9, 1'b0);
      if (v == 0) begin
        // R4 gap between slots
        n = 0;
        while (!ben[0]) begin if (tick[0]) n++; @(negedge clk); end
        check(n == GAP, "R4", n, GAP);
      end
    end

    // R5 frame marker width in port periods
    do_sof(0);
    n = 0;
    while (frame[0]) begin if (tick[0]) n++; @(negedge clk); end
    check(n == 8, "R5", n, 8);

    // R9 parity override
    @(negedge clk); cfg_ovr = 3'b001; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    do_sof(0);
    feed(0, 8'h00, 8'hFF, 0, 1'b1);
    feed(0, 8'hFF, 8'h5A, 1, 1'b1);
    feed(0, 8'hFF, 8'h2D, 2, 1'b1);

    // R10 channel independence: ch1 runs, ch2 never started
    ins[2] = 1'b1;
    din[2] = 1'b1;
    do_sof(1);
    feed(1, 8'hFF, 8'h96, 0, 1'b0);
    feed(1, 8'hFF, 8'hE1, 1, 1'b0);
    check({ben[2], vld[2], subst[2]} == 3'b000, "R10", {ben[2], vld[2], subst[2]}, 0);
    ins[2] = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule